// File: doc/BRIEF.md
# Crosspoint Switch Control Store

This block holds the on/off pattern for a grid of crosspoint switches. There are eight lines (rows) and four junctors (columns), so the grid has 32 switches. Each crosspoint has one storage cell. A set cell closes its switch and a cleared cell opens it. Every cell drives its own bit of a wide control vector at all times. There is no read port and no read strobe: whatever is stored is what the switches see.

Software or a sequencer writes the store one row at a time. It places a row number on the address bus and four switch states on the data bus, then raises the write enable. While the enable is high, the cells of the chosen row are transparent and copy the data bus. When the enable falls, they keep the last value. A master clear input empties the whole store at once and opens every crosspoint. No clock is involved anywhere.

The store has no sequencing of its own. Its behaviour amounts to three conditions per row: clear (master clear high), transparent (enable high and this row addressed, clear low) and hold (anything else). The move between transparent and hold follows the enable level directly.

Top module: `xpt_ctrl_store`

## Requirements
- R1: The store has 8 rows of 4 cells. Output bit `xpt_o[row*4 + col]` is the cell for line `row` and junctor `col`. After master clear, all 32 bits are 0.
- R2: A stored 1 drives its output bit high, which closes that crosspoint, and a stored 0 opens it. Data bit n sets junctor n of the addressed line. Writing 4'b0010 to row 4 sets only bit 17. Then writing 4'b1010 to row 4 sets bits 17 and 19 only.
- R3: The 3-bit address selects exactly one row through an active-high one-hot decode. A write alters only that row, and the other seven rows keep their contents.
- R4: While the write enable is high and master clear is low, the addressed row follows the data inputs with no clock edge. When the enable falls, the row keeps the last data it saw.
- R5: While the write enable is low, changes on the address and data inputs have no effect on any output bit.
- R6: While master clear is high, all 32 cells read 0. The clear acts asynchronously, without any clock edge.
- R7: Master clear takes priority over the write enable. If both are high, every cell stays at 0 whatever the data is.
- R8: Stored values appear on the output continuously, with no read control. They stay unchanged for as long as no write or clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mr_i | input | 1 | Master clear, active high, asynchronous |
| ae_i | input | 1 | Write enable for the addressed row, active high, level-sensitive |
| addr_i | input | 3 | Row (line) number to write |
| data_i | input | 4 | Switch states for junctors 0 to 3 of the addressed row |
| xpt_o | output | 32 | Crosspoint control vector, bit row*4+col |

## Verification
The two functions that can coincide are the row write and the master clear. Both act on the same cells, and both are plain levels, so nothing in the design orders them. The bench fills the store with a known pattern, then raises the write enable with all-ones data while master clear is already high. While both are high it checks that all 32 outputs stay at 0. It then drops the enable before the clear, so that no write slips through when the clear ends. The bench also watches every output change and flags any row that moves while neither the clear nor its own enabled window is active.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int XP_ROWS = 8;
    localparam int XP_COLS = 4;
    localparam int XP_ADDR_W = $clog2(XP_ROWS);
    localparam int XP_CELLS = XP_ROWS * XP_COLS;
endpackage

// File: rtl/xpt_row_dec.sv
module xpt_row_dec #(
    parameter int ROWS   = xpt_pkg::XP_ROWS,
    parameter int ADDR_W = xpt_pkg::XP_ADDR_W
) (
    input  logic              ae_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROWS-1:0]   en_o
);
    // One gated comparator per row; an unused code selects nothing.
    for (genvar g = 0; g < ROWS; g++) begin : g_dec
        assign en_o[g] = ae_i && (addr_i == ADDR_W'(g));
    end
endmodule

// File: rtl/xpt_cell_row.sv
module xpt_cell_row #(
    parameter int COLS = xpt_pkg::XP_COLS
) (
    input  logic            mr_i,
    input  logic            en_i,
    input  logic [COLS-1:0] d_i,
    output logic [COLS-1:0] q_o
);
    logic [COLS-1:0] cell_q;

    // Clear dominates, then transparent while enabled, else hold.
    always_latch begin
        if (mr_i) begin
            cell_q <= '0;
        end else if (en_i) begin
            cell_q <= d_i;
        end
    end

    assign q_o = cell_q;

    // R4: at the close of an enabled window the row holds the data seen.
    p_row_tracks_r4: assert property (@(negedge en_i) disable iff (mr_i)
        q_o == d_i);

    // R6: right up to the release of clear, the row is empty.
    p_clear_empty_r6: assert property (@(negedge mr_i)
        q_o == '0);

    // R7: an enabled window overlapping clear leaves the row at zero.
    p_clear_wins_r7: assert property (@(negedge en_i)
        mr_i |-> q_o == '0);
endmodule

// File: rtl/xpt_ctrl_store.sv
module xpt_ctrl_store #(
    parameter int ROWS   = xpt_pkg::XP_ROWS,
    parameter int COLS   = xpt_pkg::XP_COLS,
    parameter int ADDR_W = $clog2(ROWS)
) (
    input  logic                 mr_i,
    input  logic                 ae_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [COLS-1:0]      data_i,
    output logic [ROWS*COLS-1:0] xpt_o
);
    logic [ROWS-1:0] row_en;
    logic [COLS-1:0] row_q [ROWS];

    xpt_row_dec #(
        .ROWS   (ROWS),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .ae_i   (ae_i),
        .addr_i (addr_i),
        .en_o   (row_en)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        xpt_cell_row #(
            .COLS (COLS)
        ) u_row (
            .mr_i (mr_i),
            .en_i (row_en[g]),
            .d_i  (data_i),
            .q_o  (row_q[g])
        );
        // Row-major placement: bit row*COLS + col.
        assign xpt_o[g*COLS +: COLS] = row_q[g];
    end

    // R3: the decoder opens at most one row, and only under the enable.
    always_comb begin
        p_onehot_en_r3: assert ($onehot0(row_en) && (ae_i || row_en == '0));
    end
endmodule

// File: tb/sim_xpt_ctrl_store.sv
module sim_xpt_ctrl_store;
    localparam int ROWS = 8;
    localparam int COLS = 4;
    localparam int NB   = ROWS * COLS;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          mr;
    logic          ae;
    logic [2:0]    addr;
    logic [3:0]    data;
    logic [NB-1:0] xpt;

    logic [NB-1:0] model;
    int            n_chk = 0;
    int            n_err = 0;
    logic          done = 1'b0;

    xpt_ctrl_store u0 (
        .mr_i   (mr),
        .ae_i   (ae),
        .addr_i (addr),
        .data_i (data),
        .xpt_o  (xpt)
    );

    task automatic chk(input string tag, input logic [NB-1:0] got, input logic [NB-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // R3/R5: a row may only move under clear or inside its own enabled window.
    logic [NB-1:0] prev_x = '0;
    always @(xpt) begin
        for (int r = 0; r < ROWS; r++) begin
            if (xpt[r*COLS +: COLS] !== prev_x[r*COLS +: COLS]) begin
                n_chk++;
                if (!(mr || (ae && addr == 3'(r)))) begin
                    n_err++;
                    $display("FAIL R3 row %0d changed outside window got=%h exp=%h",
                             r, xpt[r*COLS +: COLS], prev_x[r*COLS +: COLS]);
                end
            end
        end
        prev_x = xpt;
    end

    // Write one row: set address and data with the enable low, then pulse it.
    task automatic wr(input int r, input logic [3:0] v);
        @(negedge clk);
        addr = 3'(r);
        data = v;
        @(negedge clk);
        ae = 1'b1;
        #1;
        model[r*COLS +: COLS] = v;
        chk("R4 transparent", xpt, model);
        @(negedge clk);
        ae = 1'b0;
        #1;
        chk("R3 write", xpt, model);
    endtask

    initial begin
        mr = 1'b1; ae = 1'b0; addr = '0; data = '0; model = '0;
        #1;
        chk("R6 clear at start", xpt, '0);
        repeat (3) @(negedge clk);
        mr = 1'b0;
        #1;
        chk("R1 empty after clear", xpt, '0);

        // R2 worked examples
        wr(4, 4'b0010);
        chk("R2 single junctor", xpt, NB'(1) << 17);
        wr(4, 4'b1010);
        chk("R2 two junctors", xpt, (NB'(1) << 17) | (NB'(1) << 19));

        // R1/R2/R3 exhaustive sweep of every row and every data value
        for (int r = 0; r < ROWS; r++) begin
            for (int v = 0; v < 16; v++) begin
                wr(r, 4'(v));
            end
        end
        // Distinct pattern per row
        for (int r = 0; r < ROWS; r++) wr(r, 4'(r * 5 + 3));
        chk("R1 row-major image", xpt, model);

        // R5: address/data changes with enable low do nothing
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            addr = 3'(k);
            data = 4'(~k);
            #1;
            chk("R5 enable low ignored", xpt, model);
        end

        // R8: contents persist with no activity
        repeat (200) @(negedge clk);
        chk("R8 hold", xpt, model);

        // R6: asynchronous clear between clock edges
        @(negedge clk);
        #1;
        mr = 1'b1;
        #0.5;
        chk("R6 async clear", xpt, '0);
        @(negedge clk);
        mr = 1'b0;
        model = '0;
        #1;
        chk("R6 stays clear", xpt, '0);

        // R7: clear and write in the same window
        for (int r = 0; r < ROWS; r++) wr(r, 4'hF);
        chk("R7 prefill", xpt, '1);
        @(negedge clk);
        mr = 1'b1;
        addr = 3'd2;
        data = 4'hF;
        #1;
        ae = 1'b1;
        #1;
        chk("R7 clear over write", xpt, '0);
        @(negedge clk);
        chk("R7 still clear", xpt, '0);
        ae = 1'b0;
        #1;
        mr = 1'b0;
        model = '0;
        #1;
        chk("R7 no late write", xpt, '0);

        wr(7, 4'b1001);
        chk("R3 last row", xpt, (NB'(1) << 28) | (NB'(1) << 31));
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog got=%0d exp=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule